// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Multiprocessor Bit

This block turns bytes into an asynchronous serial stream on a single output line. Software or a DMA engine places one byte in a one-deep holding buffer. The buffer feeds a shift register that emits the frame at a rate set by an external baud-enable strobe. Two status flags report progress. The buffer-empty flag (`tdre`) shows when the buffer can take a new byte. The line-done flag (`tend`) shows when the line has gone quiet with nothing left to send.

An optional multiprocessor frame format adds one extra bit after the data bits. That bit marks the frame as an ID frame (1) or a data frame (0). It comes from a control bit that is not double-buffered: the value is read at the moment the bit is on the line.

Software reaches the block through a small register bus with three addresses:

- **Address 0, control:** bit 0 is the enable, bit 1 is the multiprocessor format, bit 2 is the multiprocessor bit value.
- **Address 1, data buffer.**
- **Address 2, status:** bit 0 is `tdre`, bit 1 is `tend`.

A software byte write leaves `tdre` alone. Software commits a byte by reading status with `tdre`=1 and then writing 0 to status bit 0. A DMA strobe loads the buffer and commits the byte in one step.

Top module: `mptx_top`

## Requirements
- R1: After reset, control reads 0, status reads 3 (`tdre`=1 at bit 0, `tend`=1 at bit 1), the data buffer reads 0, and `txd` is 1.
- R2: The line idles at 1. A frame is a 0 start bit, then DATA_W data bits LSB first, then the multiprocessor bit when that format is on, then a 1 stop bit. Each bit lasts OVERSAMPLE `baud_tick` pulses.
- R3: `tdre` falls only in two cases. The first is a status write with bit 0 = 0 that directly follows a status read returning `tdre`=1, with no status write in between. The second is a DMA write. A 0-write to bit 0 without that prior read leaves `tdre` at 1.
- R4: When the shifter is idle, the block is enabled and `tdre`=0, the buffered byte moves into the shifter on the next clock and `tdre` returns to 1. A pending byte follows the previous stop bit with at most one clock of extra high level.
- R5: `tend` rises when the last bit of a frame ends while `tdre`=1. It stays 0 if a byte is pending at that moment.
- R6: `tend` falls on the software `tdre` clear of R3 and on a DMA write.
- R7: `tend` is read-only. Bus writes to status bit 1 have no effect.
- R8: While the enable bit is 0, `tend` reads 1, the shifter stops at once, `txd` is held at 1 and no byte is loaded.
- R9: In multiprocessor format, the extra bit equals control bit 2 as it stands during that bit time. A change made during the bit shows on `txd` the clock after the write.
- R10: With multiprocessor format off, control bit 2 has no effect and frames are DATA_W+2 bits long.
- R11: A DMA write and a bus write to the data buffer in the same cycle leave the DMA byte in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register address (0 control, 1 data, 2 status) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status reads arm the `tdre` clear) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| dma_wr | input | 1 | DMA write strobe: loads the buffer and clears `tdre` and `tend` |
| dma_data | input | DATA_W | DMA write data |
| baud_tick | input | 1 | Baud-enable strobe, OVERSAMPLE pulses per bit |
| txd | output | 1 | Serial output |

## Verification
The bound checker watches, on every cycle, how the flags may move. `tdre` may fall only on a DMA write or an armed zero-write, and the arm may come only from a status read that saw `tdre`=1. `tend` may rise only at a frame end with the buffer empty or while disabled. A load must be followed by an active shifter. The line must sit high when idle and low during the start bit, and frame length must match the format.

Some behaviour only the bench scenarios can show:

- the exact bit order and bit timing against a queue-based model;
- back-to-back frames with no idle gap;
- the live change of the multiprocessor bit in the middle of its bit time;
- the ignored writes to the read-only flag;
- an abort when the block is disabled.

// File: rtl/mptx_pkg.sv
package mptx_pkg;

   // Register addresses on the bus
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_DATA = 2'd1,
      REG_STAT = 2'd2,
      REG_NONE = 2'd3
   } mptx_reg_e;

   // Control register bit positions
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_MPF_BIT = 1;
   localparam int CTRL_MPB_BIT = 2;

   // Status register bit positions
   localparam int STAT_TDRE_BIT = 0;
   localparam int STAT_TEND_BIT = 1;

   typedef struct packed {
      logic mp_bit;
      logic mp_fmt;
      logic enable;
   } mptx_ctrl_t;

endpackage

// File: rtl/mptx_seq.sv
module mptx_seq #(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16,
   parameter int IDX_W      = $clog2(DATA_W + 3)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             start,
   input  logic             mp_fmt,
   input  logic             baud_tick,
   output logic             active,
   output logic [IDX_W-1:0] bit_idx,
   output logic             mp_frame,
   output logic             frame_done
);

   localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
   localparam logic [IDX_W-1:0] LAST_PLAIN = IDX_W'(DATA_W + 1);
   localparam logic [IDX_W-1:0] LAST_MP    = IDX_W'(DATA_W + 2);

   logic             bit_end;
   logic [IDX_W-1:0] last_idx;

   assign last_idx = mp_frame ? LAST_MP : LAST_PLAIN;

   generate
      if (OVERSAMPLE == 1) begin : g_direct
         assign bit_end = active & baud_tick;
      end else begin : g_divided
         logic [CNT_W-1:0] tick_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tick_q <= '0;
            end else if (!en || start) begin
               tick_q <= '0;
            end else if (active && baud_tick) begin
               if (tick_q == CNT_W'(OVERSAMPLE - 1)) tick_q <= '0;
               else                                  tick_q <= tick_q + CNT_W'(1);
            end
         end
         assign bit_end = active & baud_tick & (tick_q == CNT_W'(OVERSAMPLE - 1));
      end
   endgenerate

   assign frame_done = en & bit_end & (bit_idx == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         bit_idx  <= '0;
         mp_frame <= 1'b0;
      end else if (!en) begin
         active  <= 1'b0;
         bit_idx <= '0;
      end else if (start) begin
         active   <= 1'b1;
         bit_idx  <= '0;
         mp_frame <= mp_fmt;
      end else if (bit_end) begin
         if (bit_idx == last_idx) begin
            active  <= 1'b0;
            bit_idx <= '0;
         end else begin
            bit_idx <= bit_idx + IDX_W'(1);
         end
      end
   end

endmodule

// File: rtl/mptx_line.sv
module mptx_line #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              mp_live,
   input  logic              active,
   input  logic              mp_frame,
   input  logic [IDX_W-1:0]  bit_idx,
   output logic              txd
);

   logic [DATA_W-1:0] hold_q;
   logic [DATA_W-1:0] shifted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hold_q <= '0;
      else if (load) hold_q <= load_data;
   end

   assign shifted = hold_q >> (bit_idx - IDX_W'(1));

   // Bit 0 is the start bit, 1..DATA_W carry data, then the optional
   // multiprocessor slot and the stop bit.
   always_comb begin
      txd = 1'b1;
      if (active) begin
         if (bit_idx == '0)                                    txd = 1'b0;
         else if (bit_idx <= IDX_W'(DATA_W))                   txd = shifted[0];
         else if (mp_frame && (bit_idx == IDX_W'(DATA_W + 1))) txd = mp_live;
         else                                                  txd = 1'b1;
      end
   end

endmodule

// File: rtl/mptx_flags.sv
module mptx_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic stat_rd,
   input  logic stat_wr,
   input  logic wr_tdre_bit,
   input  logic dma_wr,
   input  logic load,
   input  logic frame_done,
   output logic tdre,
   output logic tend,
   output logic arm
);

   logic sw_clr;

   assign sw_clr = stat_wr & ~wr_tdre_bit & arm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdre <= 1'b1;
         tend <= 1'b1;
         arm  <= 1'b0;
      end else begin
         if (dma_wr || sw_clr) tdre <= 1'b0;
         else if (load)        tdre <= 1'b1;

         if (!en)                      tend <= 1'b1;
         else if (dma_wr || sw_clr)    tend <= 1'b0;
         else if (frame_done && tdre)  tend <= 1'b1;

         if (stat_wr)              arm <= 1'b0;
         else if (stat_rd && tdre) arm <= 1'b1;
      end
   end

endmodule

// File: rtl/mptx_top.sv
module mptx_top
   import mptx_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVERSAMPLE = 16,
   parameter bit MP_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              dma_wr,
   input  logic [DATA_W-1:0] dma_data,
   input  logic              baud_tick,
   output logic              txd
);

   localparam int IDX_W = $clog2(DATA_W + 3);

   generate
      if (DATA_W < 3)     begin : g_bad_width $error("DATA_W must be at least 3"); end
      if (OVERSAMPLE < 1) begin : g_bad_os    $error("OVERSAMPLE must be at least 1"); end
   endgenerate

   mptx_ctrl_t        ctrl_q;
   logic [DATA_W-1:0] buf_q;
   logic              mp_fmt_eff;
   logic              stat_rd, stat_wr;
   logic              tdre, tend, arm;
   logic              active, mp_frame, frame_done, load;
   logic [IDX_W-1:0]  bit_idx;

   assign stat_rd = bus_rd & (bus_addr == REG_STAT);
   assign stat_wr = bus_wr & (bus_addr == REG_STAT);

   generate
      if (MP_SUPPORT) begin : g_mp
         assign mp_fmt_eff = ctrl_q.mp_fmt;
      end else begin : g_nomp
         assign mp_fmt_eff = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         buf_q  <= '0;
      end else begin
         if (bus_wr && bus_addr == REG_CTRL) begin
            ctrl_q.enable <= bus_wdata[CTRL_EN_BIT];
            ctrl_q.mp_fmt <= bus_wdata[CTRL_MPF_BIT];
            ctrl_q.mp_bit <= bus_wdata[CTRL_MPB_BIT];
         end
         if (dma_wr)                              buf_q <= dma_data;
         else if (bus_wr && bus_addr == REG_DATA) buf_q <= bus_wdata;
      end
   end

   assign load = ctrl_q.enable & ~active & ~tdre;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         REG_CTRL: begin
            bus_rdata[CTRL_EN_BIT]  = ctrl_q.enable;
            bus_rdata[CTRL_MPF_BIT] = ctrl_q.mp_fmt;
            bus_rdata[CTRL_MPB_BIT] = ctrl_q.mp_bit;
         end
         REG_DATA: bus_rdata = buf_q;
         REG_STAT: begin
            bus_rdata[STAT_TDRE_BIT] = tdre;
            bus_rdata[STAT_TEND_BIT] = tend;
         end
         default:  bus_rdata = '0;
      endcase
   end

   mptx_flags u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ctrl_q.enable),
      .stat_rd    (stat_rd),
      .stat_wr    (stat_wr),
      .wr_tdre_bit(bus_wdata[STAT_TDRE_BIT]),
      .dma_wr     (dma_wr),
      .load       (load),
      .frame_done (frame_done),
      .tdre       (tdre),
      .tend       (tend),
      .arm        (arm)
   );

   mptx_seq #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE), .IDX_W(IDX_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctrl_q.enable),
      .start     (load),
      .mp_fmt    (mp_fmt_eff),
      .baud_tick (baud_tick),
      .active    (active),
      .bit_idx   (bit_idx),
      .mp_frame  (mp_frame),
      .frame_done(frame_done)
   );

   mptx_line #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_data(buf_q),
      .mp_live  (ctrl_q.mp_bit),
      .active   (active),
      .mp_frame (mp_frame),
      .bit_idx  (bit_idx),
      .txd      (txd)
   );

endmodule

// File: rtl/mptx_chk.sv
module mptx_chk #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = $clog2(DATA_W + 3)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             tdre,
   input logic             tend,
   input logic             arm,
   input logic             dma_wr,
   input logic             stat_wr,
   input logic             stat_rd,
   input logic             wr_tdre_bit,
   input logic             load,
   input logic             frame_done,
   input logic             active,
   input logic [IDX_W-1:0] bit_idx,
   input logic             mp_frame,
   input logic             txd
);

   // R3
   tdre_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tdre) |-> $past(dma_wr || (stat_wr && !wr_tdre_bit && arm)));

   // R3
   arm_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arm) |-> $past(stat_rd && tdre));

   // R4
   load_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> active);

   // R5
   tend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tend) |-> $past(!en || (frame_done && tdre)));

   // R6
   tend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tend) |-> $past(dma_wr || (stat_wr && !wr_tdre_bit && arm)));

   // R8
   disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (tend && !active));

   // R2
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> txd);

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && bit_idx == '0) |-> !txd);

   // R10
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !mp_frame) |-> (bit_idx <= IDX_W'(DATA_W + 1)));

endmodule

bind mptx_top mptx_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .en         (ctrl_q.enable),
   .tdre       (tdre),
   .tend       (tend),
   .arm        (arm),
   .dma_wr     (dma_wr),
   .stat_wr    (stat_wr),
   .stat_rd    (stat_rd),
   .wr_tdre_bit(bus_wdata[0]),
   .load       (load),
   .frame_done (frame_done),
   .active     (active),
   .bit_idx    (bit_idx),
   .mp_frame   (mp_frame),
   .txd        (txd)
);

// File: tb/mptx_top_bench.sv
module mptx_top_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       dma_wr = 1'b0;
   logic [7:0] dma_data = 8'd0;
   logic       baud_tick = 1'b0;
   logic       txd;

   int checks = 0, errors = 0;
   string ptag = "R2";

   // behavioural reference state
   int   m_q[$];
   bit   m_active;
   int   m_tick;
   bit   m_tdre, m_tend, m_arm;
   logic [7:0] m_buf;
   logic [2:0] m_ctrl;

   always #10 clk = ~clk;

   mptx_top u_mptx_top (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dma_wr(dma_wr), .dma_data(dma_data), .baud_tick(baud_tick), .txd(txd)
   );

   always @(posedge clk or negedge rst_n) begin
      bit en_o, tdre_o, done, ld, stwr, swclr;
      if (!rst_n) begin
         m_q.delete(); m_active = 0; m_tick = 0;
         m_tdre = 1; m_tend = 1; m_arm = 0; m_buf = 0; m_ctrl = 0;
      end else begin
         en_o = m_ctrl[0]; tdre_o = m_tdre; done = 0; ld = 0;
         stwr  = bus_wr && bus_addr == 2'd2;
         swclr = stwr && !bus_wdata[0] && m_arm;
         if (!en_o) begin
            m_active = 0; m_q.delete(); m_tick = 0;
         end else if (m_active) begin
            if (baud_tick) begin
               m_tick++;
               if (m_tick == 16) begin
                  m_tick = 0;
                  void'(m_q.pop_front());
                  if (m_q.size() == 0) begin m_active = 0; done = 1; end
               end
            end
         end else if (!tdre_o) begin
            ld = 1; m_tick = 0; m_q.delete();
            m_q.push_back(0);
            for (int i = 0; i < 8; i++) m_q.push_back(int'(m_buf[i]));
            if (m_ctrl[1]) m_q.push_back(2);
            m_q.push_back(1);
            m_active = 1;
         end
         if (dma_wr || swclr) m_tdre = 0;
         else if (ld)         m_tdre = 1;
         if (!en_o)                m_tend = 1;
         else if (dma_wr || swclr) m_tend = 0;
         else if (done && tdre_o)  m_tend = 1;
         if (stwr)                          m_arm = 0;
         else if (bus_rd && bus_addr == 2'd2 && tdre_o) m_arm = 1;
         if (dma_wr)                             m_buf = dma_data;
         else if (bus_wr && bus_addr == 2'd1)    m_buf = bus_wdata;
         if (bus_wr && bus_addr == 2'd0)         m_ctrl = bus_wdata[2:0];
      end
   end

   function automatic logic exp_txd();
      if (!m_active || m_q.size() == 0) return 1'b1;
      if (m_q[0] == 2) return m_ctrl[2];
      return m_q[0][0];
   endfunction

   // line compared with the model on every clock
   always @(negedge clk) if (rst_n) begin
      logic e;
      e = exp_txd();
      checks++;
      if (txd !== e) begin
         errors++;
         $display("FAIL %s txd at %0t: got %b expected %b", ptag, $time, txd, e);
      end
   end

   // baud strobe: one pulse every 4 clocks
   initial begin
      int n = 0;
      forever begin
         @(negedge clk);
         baud_tick = (n % 4 == 0);
         n++;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic dma(input logic [7:0] d, input bit with_bus);
      @(negedge clk); dma_data = d; dma_wr = 1;
      if (with_bus) begin bus_addr = 2'd1; bus_wdata = ~d; bus_wr = 1; end
      @(negedge clk); dma_wr = 0; bus_wr = 0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input string tag);
      logic [7:0] e;
      @(negedge clk); bus_addr = a; bus_rd = 1;
      #1;
      case (a)
         2'd0:    e = {5'd0, m_ctrl};
         2'd1:    e = m_buf;
         2'd2:    e = {6'd0, m_tend, m_tdre};
         default: e = 8'd0;
      endcase
      checks++;
      if (bus_rdata !== e) begin
         errors++;
         $display("FAIL %s read addr %0d: got %h expected %h", tag, a, bus_rdata, e);
      end
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic commit(input logic [7:0] d);
      wr(2'd1, d);
      rd_chk(2'd2, "R3");
      wr(2'd2, 8'h00);
   endtask

   task automatic wait_idle();
      while (m_active || !m_tdre) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic expect_bit(input logic got, input logic exp, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %b expected %b", tag, got, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_bit(txd, 1'b1, "R1 idle line");
      rst_n = 1;
      rd_chk(2'd0, "R1"); rd_chk(2'd1, "R1"); rd_chk(2'd2, "R1");

      // R8: disabled, TEND forced, no load even after a commit
      commit(8'h5A);
      repeat (20) @(negedge clk);
      rd_chk(2'd2, "R8");
      expect_bit(txd, 1'b1, "R8 line held");

      // enable, plain frames
      wr(2'd0, 8'h01);
      wait_idle();
      rd_chk(2'd2, "R5");
      // R3: zero write without read leaves TDRE set
      wr(2'd2, 8'h00);
      rd_chk(2'd2, "R3");
      wr(2'd2, 8'h00);
      // R3: stale arm was consumed by the write above; another write is void
      wr(2'd2, 8'h00);
      rd_chk(2'd2, "R3");

      // R2/R4/R5: back-to-back frames
      commit(8'hA5);
      rd_chk(2'd2, "R4");
      commit(8'h3C);
      rd_chk(2'd2, "R6");
      while (m_q.size() != 1 || !m_active) @(negedge clk);
      rd_chk(2'd2, "R5");
      wait_idle();
      rd_chk(2'd2, "R5");

      // R7: TEND read-only
      rd_chk(2'd2, "R7");
      wr(2'd2, 8'h01);
      rd_chk(2'd2, "R7");
      wr(2'd2, 8'h03);
      rd_chk(2'd2, "R7");

      // R6/R11: DMA load with a concurrent bus write to the buffer
      ptag = "R6";
      dma(8'hC3, 1'b1);
      rd_chk(2'd1, "R11");
      wait_idle();
      rd_chk(2'd2, "R6");

      // R9: multiprocessor frame, bit changed while on the line
      ptag = "R9";
      wr(2'd0, 8'h07);
      commit(8'h81);
      while (!(m_active && m_q.size() > 0 && m_q[0] == 2 && m_tick == 4)) @(negedge clk);
      expect_bit(txd, 1'b1, "R9 id bit");
      wr(2'd0, 8'h03);
      expect_bit(txd, 1'b0, "R9 live change");
      wait_idle();

      // R10: format off, MPBT set but ignored
      ptag = "R10";
      wr(2'd0, 8'h05);
      commit(8'hF0);
      wait_idle();
      rd_chk(2'd2, "R10");

      // R8: disable in the middle of a frame
      ptag = "R8";
      commit(8'h0F);
      repeat (100) @(negedge clk);
      wr(2'd0, 8'h00);
      @(negedge clk);
      expect_bit(txd, 1'b1, "R8 abort");
      rd_chk(2'd2, "R8");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule